// File: doc/BRIEF.md
# Instruction Operand Field Extractor

This block takes one 16-bit instruction word of an 8-bit RISC microcontroller, the program word that follows it, and the program counter of the instruction. From these it rebuilds every operand an instruction of that family may carry. The outputs are register indices, immediates, I/O addresses, bit selectors, load/store displacements and resolved jump and branch targets.

Most operands are not stored as one contiguous run of bits. Their bits are scattered across the opcode. The block regroups them, adds fixed offsets and sign-extends them as each field type requires.

Every field is produced in parallel, with no clock and no latency. The instruction decoder downstream picks the outputs that match the instruction it has classified. Program memory size is a parameter. PC-relative jump targets wrap inside that size, and the wrap logic handles sizes that are not a power of two.

Top module: `opx_field_extract`

## Requirements
- R1: `rd_o` equals opcode bits 8:4, covering registers 0 to 31.
- R2: `rd_hi_o` equals 16 plus opcode bits 7:4, so it always lies in 16 to 31.
- R3: `rr_o` has opcode bit 9 as its top bit, with opcode bits 3:0 below it.
- R4: `imm8_o` has opcode bits 11:8 as its upper nibble and bits 3:0 as its lower nibble.
- R5: The word add/subtract operands are `imm6_o`, built as {bits 7:6, bits 3:0}, and `rpair_o`. `rpair_o` equals 24 + 2 × bits 5:4, so it is always one of 24, 26, 28 or 30.
- R6: `io6_o` is {bits 10:9, bits 3:0}. `io6_daddr_o` equals `io6_o` + IO_BASE, where IO_BASE defaults to 0x20.
- R7: `io5_o` is opcode bits 7:3. `io5_daddr_o` equals `io5_o` + IO_BASE.
- R8: `disp6_o` is built from bit 13 at the top, then bits 11:10, then bits 2:0 at the bottom.
- R9: `sbit_o` equals opcode bits 6:4, and `rbit_o` equals opcode bits 2:0.
- R10: `brn_tgt_o` is a two's-complement value equal to PC + 1 + d. Here d is the 7-bit field in bits 9:3, sign-extended to the range -64..63. The result is not wrapped.
- R11: `rel_tgt_o` equals (PC + 1 + d) mod PMEM_WORDS, taken as a non-negative value. Here d is opcode bits 11:0, sign-extended to the range -2048..2047. This holds for memory sizes that are powers of two and for sizes that are not.
- R12: `lng_tgt_o` has {bits 8:4, bit 0} as its upper six bits and the second program word `ext_i` as its lower 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 16 | Instruction word |
| ext_i | input | 16 | Program word following the instruction |
| pc_i | input | PC_W ($clog2(PMEM_WORDS), 13) | Address of the instruction |
| rd_o | output | 5 | Full-range destination register |
| rd_hi_o | output | 5 | Upper-half destination register |
| rr_o | output | 5 | Full-range source register |
| rpair_o | output | 5 | Low register of the word-op pair |
| imm8_o | output | 8 | 8-bit immediate |
| imm6_o | output | 6 | Word-op 6-bit immediate |
| io6_o | output | 6 | 6-bit I/O address |
| io6_daddr_o | output | DADDR_W (16) | 6-bit I/O address mapped to data space |
| io5_o | output | 5 | 5-bit I/O address of bit ops |
| io5_daddr_o | output | DADDR_W (16) | 5-bit I/O address mapped to data space |
| disp6_o | output | 6 | Indexed load/store displacement |
| sbit_o | output | 3 | Status-register bit selector |
| rbit_o | output | 3 | Register bit number |
| brn_tgt_o | output | PC_W+2 (15) | Conditional branch target, signed |
| rel_tgt_o | output | PC_W (13) | Relative jump/call target, wrapped |
| lng_tgt_o | output | 22 | Long jump/call target |

## Verification
The bench builds two instances. The first uses the default 8192-word memory, where wrapping is plain truncation. The second uses 6000 words, which reaches the add-or-subtract correction path of the relative target that a power-of-two size never exercises. Directed vectors place the program counter at 0 and at the last word, with displacements at their extremes. These vectors cover both wrap directions, the most negative branch result and a branch result above the memory top. Random opcodes and program counters then compare every field with an arithmetic model.

// File: rtl/opx_pkg.sv
`timescale 1ns/1ps
package opx_pkg;
  localparam int unsigned INSN_W   = 16;
  localparam int unsigned RIDX_W   = 5;
  localparam int unsigned BDISP_W  = 7;
  localparam int unsigned RDISP_W  = 12;
  localparam int unsigned LHI_W    = 6;
  localparam int unsigned LNG_W    = LHI_W + INSN_W;

  typedef logic [INSN_W-1:0] insn_t;
  typedef logic [RIDX_W-1:0] ridx_t;
endpackage

// File: rtl/opx_reg_fields.sv
`timescale 1ns/1ps
module opx_reg_fields
  import opx_pkg::*;
(
  input  insn_t op_i,
  output ridx_t rd_o,
  output ridx_t rd_hi_o,
  output ridx_t rr_o,
  output ridx_t rpair_o
);
  assign rd_o    = op_i[8:4];
  assign rd_hi_o = {1'b1, op_i[7:4]};        // 16 + bits 7:4
  assign rr_o    = {op_i[9], op_i[3:0]};
  assign rpair_o = {2'b11, op_i[5:4], 1'b0};  // 24 + 2*bits 5:4
endmodule

// File: rtl/opx_imm_fields.sv
`timescale 1ns/1ps
module opx_imm_fields
  import opx_pkg::*;
#(
  parameter int unsigned IO_BASE = 32,
  parameter int unsigned DADDR_W = 16
) (
  input  insn_t              op_i,
  output logic [7:0]         imm8_o,
  output logic [5:0]         imm6_o,
  output logic [5:0]         io6_o,
  output logic [DADDR_W-1:0] io6_daddr_o,
  output logic [4:0]         io5_o,
  output logic [DADDR_W-1:0] io5_daddr_o,
  output logic [5:0]         disp6_o,
  output logic [2:0]         sbit_o,
  output logic [2:0]         rbit_o
);
  localparam logic [DADDR_W-1:0] BASE = DADDR_W'(IO_BASE);

  logic [5:0] io6;
  logic [4:0] io5;

  assign imm8_o  = {op_i[11:8], op_i[3:0]};
  assign imm6_o  = {op_i[7:6], op_i[3:0]};
  assign io6     = {op_i[10:9], op_i[3:0]};
  assign io5     = op_i[7:3];
  assign io6_o   = io6;
  assign io5_o   = io5;
  assign io6_daddr_o = BASE + DADDR_W'(io6);
  assign io5_daddr_o = BASE + DADDR_W'(io5);
  assign disp6_o = {op_i[13], op_i[11:10], op_i[2:0]};
  assign sbit_o  = op_i[6:4];
  assign rbit_o  = op_i[2:0];
endmodule

// File: rtl/opx_targets.sv
`timescale 1ns/1ps
module opx_targets
  import opx_pkg::*;
#(
  parameter int unsigned PMEM_WORDS = 8192,
  localparam int unsigned PC_W  = $clog2(PMEM_WORDS),
  localparam int unsigned BT_W  = PC_W + 2
) (
  input  insn_t              op_i,
  input  insn_t              ext_i,
  input  logic [PC_W-1:0]    pc_i,
  output logic [BT_W-1:0]    brn_tgt_o,
  output logic [PC_W-1:0]    rel_tgt_o,
  output logic [LNG_W-1:0]   lng_tgt_o
);
  localparam int unsigned SUM_W  = ((PC_W > RDISP_W) ? PC_W : RDISP_W) + 2;
  localparam bit          IS_POW2 = (PMEM_WORDS == (1 << PC_W));

  // branch: unwrapped signed result
  logic [BT_W-1:0] bdisp;
  assign bdisp     = {{(BT_W-BDISP_W){op_i[9]}}, op_i[9:3]};
  assign brn_tgt_o = {2'b00, pc_i} + BT_W'(1) + bdisp;

  // relative jump/call: wraps inside program memory
  logic [SUM_W-1:0] rdisp, rsum;
  assign rdisp = {{(SUM_W-RDISP_W){op_i[11]}}, op_i[11:0]};
  assign rsum  = {{(SUM_W-PC_W){1'b0}}, pc_i} + SUM_W'(1) + rdisp;

  generate
    if (IS_POW2) begin : g_wrap_trunc
      assign rel_tgt_o = rsum[PC_W-1:0];
    end else begin : g_wrap_fold
      localparam logic [SUM_W-1:0] MEM = SUM_W'(PMEM_WORDS);
      logic [SUM_W-1:0] fold;
      // one correction suffices while PMEM_WORDS exceeds the displacement span
      always_comb begin
        if (rsum[SUM_W-1])  fold = rsum + MEM;
        else if (rsum >= MEM) fold = rsum - MEM;
        else                fold = rsum;
      end
      assign rel_tgt_o = fold[PC_W-1:0];
    end
  endgenerate

  assign lng_tgt_o = {op_i[8:4], op_i[0], ext_i};
endmodule

// File: rtl/opx_field_extract.sv
`timescale 1ns/1ps
module opx_field_extract
  import opx_pkg::*;
#(
  parameter int unsigned PMEM_WORDS = 8192,
  parameter int unsigned IO_BASE    = 32,
  parameter int unsigned DADDR_W    = 16,
  localparam int unsigned PC_W = $clog2(PMEM_WORDS),
  localparam int unsigned BT_W = PC_W + 2
) (
  input  logic [15:0]        op_i,
  input  logic [15:0]        ext_i,
  input  logic [PC_W-1:0]    pc_i,
  output logic [4:0]         rd_o,
  output logic [4:0]         rd_hi_o,
  output logic [4:0]         rr_o,
  output logic [4:0]         rpair_o,
  output logic [7:0]         imm8_o,
  output logic [5:0]         imm6_o,
  output logic [5:0]         io6_o,
  output logic [DADDR_W-1:0] io6_daddr_o,
  output logic [4:0]         io5_o,
  output logic [DADDR_W-1:0] io5_daddr_o,
  output logic [5:0]         disp6_o,
  output logic [2:0]         sbit_o,
  output logic [2:0]         rbit_o,
  output logic [BT_W-1:0]    brn_tgt_o,
  output logic [PC_W-1:0]    rel_tgt_o,
  output logic [21:0]        lng_tgt_o
);
  opx_reg_fields u_reg (
    .op_i    (op_i),
    .rd_o    (rd_o),
    .rd_hi_o (rd_hi_o),
    .rr_o    (rr_o),
    .rpair_o (rpair_o)
  );

  opx_imm_fields #(
    .IO_BASE (IO_BASE),
    .DADDR_W (DADDR_W)
  ) u_imm (
    .op_i        (op_i),
    .imm8_o      (imm8_o),
    .imm6_o      (imm6_o),
    .io6_o       (io6_o),
    .io6_daddr_o (io6_daddr_o),
    .io5_o       (io5_o),
    .io5_daddr_o (io5_daddr_o),
    .disp6_o     (disp6_o),
    .sbit_o      (sbit_o),
    .rbit_o      (rbit_o)
  );

  opx_targets #(
    .PMEM_WORDS (PMEM_WORDS)
  ) u_tgt (
    .op_i      (op_i),
    .ext_i     (ext_i),
    .pc_i      (pc_i),
    .brn_tgt_o (brn_tgt_o),
    .rel_tgt_o (rel_tgt_o),
    .lng_tgt_o (lng_tgt_o)
  );
endmodule

// File: rtl/opx_field_extract_chk.sv
`timescale 1ns/1ps
module opx_field_extract_chk #(
  parameter int unsigned PMEM_WORDS = 8192,
  parameter int unsigned IO_BASE    = 32,
  parameter int unsigned DADDR_W    = 16,
  localparam int unsigned PC_W = $clog2(PMEM_WORDS),
  localparam int unsigned BT_W = PC_W + 2
) (
  input logic [15:0]        ext_i,
  input logic [PC_W-1:0]    pc_i,
  input logic [4:0]         rd_o,
  input logic [4:0]         rd_hi_o,
  input logic [4:0]         rr_o,
  input logic [4:0]         rpair_o,
  input logic [7:0]         imm8_o,
  input logic [5:0]         imm6_o,
  input logic [5:0]         io6_o,
  input logic [DADDR_W-1:0] io6_daddr_o,
  input logic [4:0]         io5_o,
  input logic [DADDR_W-1:0] io5_daddr_o,
  input logic [BT_W-1:0]    brn_tgt_o,
  input logic [PC_W-1:0]    rel_tgt_o,
  input logic [21:0]        lng_tgt_o
);
  always_comb begin
    p_hi_half_r2: assert (rd_hi_o >= 5'd16 && rd_hi_o[3:0] == rd_o[3:0])
      else $error("rd_hi_o outside upper half");
    p_src_low_r3: assert (rr_o[3:0] == imm8_o[3:0])
      else $error("rr_o low nibble mismatch");
    p_pair_r5: assert (rpair_o >= 5'd24 && !rpair_o[0] && rpair_o[2:1] == rd_o[1:0])
      else $error("rpair_o not an even pair in 24..30");
    p_io6_window_r6: assert (io6_daddr_o >= DADDR_W'(IO_BASE)
                             && io6_daddr_o < DADDR_W'(IO_BASE + 64)
                             && io6_daddr_o[3:0] == imm6_o[3:0])
      else $error("io6_daddr_o outside I/O window");
    p_io5_window_r7: assert (io5_daddr_o >= DADDR_W'(IO_BASE)
                             && io5_daddr_o < DADDR_W'(IO_BASE + 32)
                             && io5_o[0] == rr_o[3])
      else $error("io5_daddr_o outside low I/O window");
    p_io_nest_r6: assert (io6_o[3:0] == imm8_o[3:0])
      else $error("io6_o low bits mismatch");
    p_rel_inside_r11: assert (32'(rel_tgt_o) < PMEM_WORDS)
      else $error("rel_tgt_o beyond program memory");
    p_brn_span_r10: assert ($signed(brn_tgt_o) - $signed({2'b00, pc_i}) <= 64
                            && $signed(brn_tgt_o) - $signed({2'b00, pc_i}) >= -63)
      else $error("brn_tgt_o outside branch span");
    p_lng_low_r12: assert (lng_tgt_o[15:0] == ext_i)
      else $error("lng_tgt_o low word mismatch");
  end
endmodule

bind opx_field_extract opx_field_extract_chk #(
  .PMEM_WORDS (PMEM_WORDS),
  .IO_BASE    (IO_BASE),
  .DADDR_W    (DADDR_W)
) u_chk (
  .ext_i       (ext_i),
  .pc_i        (pc_i),
  .rd_o        (rd_o),
  .rd_hi_o     (rd_hi_o),
  .rr_o        (rr_o),
  .rpair_o     (rpair_o),
  .imm8_o      (imm8_o),
  .imm6_o      (imm6_o),
  .io6_o       (io6_o),
  .io6_daddr_o (io6_daddr_o),
  .io5_o       (io5_o),
  .io5_daddr_o (io5_daddr_o),
  .brn_tgt_o   (brn_tgt_o),
  .rel_tgt_o   (rel_tgt_o),
  .lng_tgt_o   (lng_tgt_o)
);

// File: tb/sim_opx_field_extract.sv
`timescale 1ns/1ps
module sim_opx_field_extract;
  localparam int M0 = 8192;
  localparam int M1 = 6000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] op, ext;
  logic [12:0] pc0, pc1;

  logic [4:0]  rd, rd_hi, rr, rpair, io5;
  logic [7:0]  imm8;
  logic [5:0]  imm6, io6, disp6;
  logic [15:0] io6_da, io5_da;
  logic [2:0]  sbit, rbit;
  logic signed [14:0] brn0, brn1;
  logic [12:0] rel0, rel1;
  logic [21:0] lng0, lng1;

  logic [4:0]  x_rd, x_rdh, x_rr, x_rp, x_io5;
  logic [7:0]  x_i8;
  logic [5:0]  x_i6, x_io6, x_d6;
  logic [15:0] x_da6, x_da5;
  logic [2:0]  x_sb, x_rb;

  opx_field_extract u0 (
    .op_i(op), .ext_i(ext), .pc_i(pc0),
    .rd_o(rd), .rd_hi_o(rd_hi), .rr_o(rr), .rpair_o(rpair),
    .imm8_o(imm8), .imm6_o(imm6), .io6_o(io6), .io6_daddr_o(io6_da),
    .io5_o(io5), .io5_daddr_o(io5_da), .disp6_o(disp6),
    .sbit_o(sbit), .rbit_o(rbit),
    .brn_tgt_o(brn0), .rel_tgt_o(rel0), .lng_tgt_o(lng0)
  );

  opx_field_extract #(.PMEM_WORDS(M1)) u1 (
    .op_i(op), .ext_i(ext), .pc_i(pc1),
    .rd_o(x_rd), .rd_hi_o(x_rdh), .rr_o(x_rr), .rpair_o(x_rp),
    .imm8_o(x_i8), .imm6_o(x_i6), .io6_o(x_io6), .io6_daddr_o(x_da6),
    .io5_o(x_io5), .io5_daddr_o(x_da5), .disp6_o(x_d6),
    .sbit_o(x_sb), .rbit_o(x_rb),
    .brn_tgt_o(brn1), .rel_tgt_o(rel1), .lng_tgt_o(lng1)
  );

  typedef struct packed {
    logic [15:0] op;
    logic [12:0] pc;
    logic [15:0] ext;
    logic signed [31:0] brn;
    logic [12:0] rel;
    logic [21:0] lng;
  } vec_t;

  // corners at PC 0 / last word with extreme displacements (M0 = 8192)
  localparam vec_t TBL [8] = '{
    '{16'h0000, 13'd0,    16'h0000, 32'sd1,    13'd1,    22'h000000},
    '{16'hCFFF, 13'd0,    16'h1234, 32'sd0,    13'd0,    22'h3F1234},
    '{16'hC800, 13'd0,    16'hFFFF, 32'sd1,    13'd6145, 22'h00FFFF},
    '{16'hC7FF, 13'd8191, 16'h0000, 32'sd8191, 13'd2047, 22'h3F0000},
    '{16'hF1F8, 13'd8191, 16'h0001, 32'sd8255, 13'd504,  22'h3E0001},
    '{16'hF200, 13'd0,    16'hABCD, -32'sd63,  13'd513,  22'h00ABCD},
    '{16'h0001, 13'd100,  16'h5555, 32'sd101,  13'd102,  22'h015555},
    '{16'h0010, 13'd8191, 16'h0000, 32'sd8194, 13'd16,   22'h020000}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d (op=%h pc=%0d)", req, act, exp, op, pc0);
    end
  endtask

  function automatic int sx(input int v, input int bits);
    return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
  endfunction

  task automatic check_fields();
    int o;
    o = int'(op);
    chk("R1 rd",     rd,    (o >> 4) & 31);
    chk("R2 rd_hi",  rd_hi, 16 + ((o >> 4) & 15));
    chk("R3 rr",     rr,    ((o >> 9) & 1) * 16 + (o & 15));
    chk("R4 imm8",   imm8,  ((o >> 8) & 15) * 16 + (o & 15));
    chk("R5 imm6",   imm6,  ((o >> 6) & 3) * 16 + (o & 15));
    chk("R5 pair",   rpair, 24 + 2 * ((o >> 4) & 3));
    chk("R6 io6",    io6,   ((o >> 9) & 3) * 16 + (o & 15));
    chk("R6 io6 da", io6_da, 32 + ((o >> 9) & 3) * 16 + (o & 15));
    chk("R7 io5",    io5,   (o >> 3) & 31);
    chk("R7 io5 da", io5_da, 32 + ((o >> 3) & 31));
    chk("R8 disp6",  disp6, ((o >> 13) & 1) * 32 + ((o >> 10) & 3) * 8 + (o & 7));
    chk("R9 sbit",   sbit,  (o >> 4) & 7);
    chk("R9 rbit",   rbit,  o & 7);
  endtask

  task automatic check_targets();
    int o, d7, d12, s;
    o   = int'(op);
    d7  = sx((o >> 3) & 127, 7);
    d12 = sx(o & 4095, 12);
    chk("R10 brn u0", brn0, int'(pc0) + 1 + d7);
    chk("R10 brn u1", brn1, int'(pc1) + 1 + d7);
    s = int'(pc0) + 1 + d12;
    chk("R11 rel u0", rel0, ((s % M0) + M0) % M0);
    s = int'(pc1) + 1 + d12;
    chk("R11 rel u1", rel1, ((s % M1) + M1) % M1);
    chk("R12 lng",    lng0, ((((o >> 4) & 31) * 2 + (o & 1)) * 65536) + int'(ext));
    chk("R12 lng u1", lng1, ((((o >> 4) & 31) * 2 + (o & 1)) * 65536) + int'(ext));
  endtask

  initial begin
    op = '0; ext = '0; pc0 = '0; pc1 = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // all-zero word: every field at its floor
    chk("R1 zero rd", rd, 0);
    chk("R2 zero rd_hi", rd_hi, 16);
    chk("R6 zero io6 da", io6_da, 32);
    chk("R10 zero brn", brn0, 1);

    foreach (TBL[i]) begin
      @(posedge clk);
      op = TBL[i].op; ext = TBL[i].ext; pc0 = TBL[i].pc; pc1 = '0;
      @(negedge clk);
      chk("R10 tbl brn", brn0, TBL[i].brn);
      chk("R11 tbl rel", rel0, TBL[i].rel);
      chk("R12 tbl lng", lng0, TBL[i].lng);
      check_fields();
    end

    // non-power-of-two wrap corners (M1 = 6000)
    @(posedge clk);
    op = 16'hC7FF; pc1 = 13'd5999;          // 5999+1+2047 = 8047 -> 2047
    @(negedge clk);
    chk("R11 fold high", rel1, 2047);
    @(posedge clk);
    op = 16'hC800; pc1 = 13'd0;             // -2047 -> 3953
    @(negedge clk);
    chk("R11 fold low", rel1, 3953);
    @(posedge clk);
    op = 16'hCFFF; pc1 = 13'd5999;          // 5999 exactly -> 5999
    @(negedge clk);
    chk("R11 fold edge", rel1, 5999);

    for (int k = 0; k < 3000; k++) begin
      @(posedge clk);
      op  = 16'($urandom);
      ext = 16'($urandom);
      pc0 = 13'($urandom);
      pc1 = 13'($urandom % M1);
      @(negedge clk);
      check_fields();
      check_targets();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule